// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps one private cache coherent with its peers on a shared, write-back, write-invalidate snooping bus. It holds the tag and coherence state of every line of a small direct-mapped cache. Processor loads and stores are checked against that state. Anything the line cannot satisfy locally becomes a single bus request: a fill for reading, a fill with ownership, an ownership upgrade, or a write-back of a dirty victim. The data array, bus arbitration and main memory live outside the block. Every bus transaction is atomic and completes in the cycle it is granted.

At the same time the block watches transactions that other caches put on the bus. It updates its own copy and answers on three wired-OR lines. The first says a valid copy is held. The second says a dirty copy is held, which the block supplies and writes back. The third asks the bus to wait one cycle. It is raised when the snoop lands in the same cycle as a processor tag lookup.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid: `cpu_req_ready` is high, `bus_req_valid` and `cpu_done` are low, and a snoop of any address raises neither `snp_has_copy` nor `snp_has_dirty`.
- R2: A store that misses issues read-exclusive (`bus_req_cmd` = 2) at the request address, and the line is then modified.
- R3: A store to a shared line issues an upgrade (`bus_req_cmd` = 3) with no fill, and the line is then modified.
- R4: A store to an exclusive-clean line, and any load or store that hits without needing the bus, completes with `cpu_done` one cycle after acceptance and no bus request. An exclusive-clean line written this way becomes modified.
- R5: A load that misses issues a read (`bus_req_cmd` = 1). The line becomes exclusive-clean if `bus_shared_in` is low in the grant cycle, and shared otherwise.
- R6: A snooped read (`snp_cmd` = 1) hitting an exclusive-clean or shared line asserts `snp_has_copy` only and leaves the line shared.
- R7: A snooped read or read-exclusive hitting a modified line asserts both `snp_has_copy` and `snp_has_dirty`. The line then becomes shared after a read, or invalid after a read-exclusive.
- R8: A snooped read-exclusive or upgrade (`snp_cmd` = 2 or 3) hitting a valid line asserts `snp_has_copy` and invalidates it. A snooped write-back (`snp_cmd` = 0), or a snoop whose tag does not match, drives no response and changes nothing.
- R9: A miss whose victim is modified first issues a write-back (`bus_req_cmd` = 0) at the victim address and then the fill. A shared or exclusive-clean victim is dropped without any bus traffic.
- R10: A snoop in the same cycle as an accepted processor request raises `snp_wait` for exactly that cycle. Its result appears in the next cycle against the updated line, and `cpu_req_ready` is low during that next cycle.
- R11: `bus_req_valid` stays high until `bus_req_grant`, with one request at a time, and `cpu_req_ready` stays low while it is high. `cpu_done` pulses in the cycle after the final grant.
- R12: If a pending upgrade's shared copy is invalidated by a snoop before grant, the request becomes read-exclusive.

Addresses split into index = the low `IDX_W` bits and tag = the remaining high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_req_ready | output | 1 | Controller can accept a request this cycle |
| cpu_done | output | 1 | One-cycle pulse: request finished |
| bus_req_valid | output | 1 | Bus request outstanding |
| bus_req_cmd | output | 2 | 0 write-back, 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_addr | output | ADDR_W | Address of the bus request |
| bus_req_grant | input | 1 | Request granted; transaction completes this cycle |
| bus_shared_in | input | 1 | Wired-OR copy line from the other caches, read at grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_has_copy | output | 1 | This cache holds a valid copy |
| snp_has_dirty | output | 1 | This cache holds a modified copy and supplies it |
| snp_wait | output | 1 | Snoop result not yet ready; hold one cycle |

## Verification
The snoop outputs are combinational in the cycle the snoop is processed. The bench therefore drives a snoop just after a falling edge and reads the response a moment later in the same cycle. A colliding snoop is instead read in the following cycle, with `snp_wait` read in the first. `cpu_done` and the first `bus_req_valid` are registered and appear one cycle after the accepting edge. Each grant finishes its transaction at that edge, so the bench grants on the falling edge where it sees a request and looks for the next request or the done pulse one cycle later. Line states cannot be read out directly, so they are inferred from later traffic: whether a store needs an upgrade, and whether a snoop reports a dirty copy.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_WB  = 2'd0,
        CMD_RD  = 2'd1,
        CMD_RDX = 2'd2,
        CMD_UPG = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [TAG_W-1:0] ra_tag,
    output line_st_t         ra_st,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [TAG_W-1:0] rb_tag,
    output line_st_t         rb_st,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag,
    input  line_st_t         w_st
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TAG_W-1:0] tag_d [DEPTH];
    line_st_t         st_q  [DEPTH];
    line_st_t         st_d  [DEPTH];

    always_comb begin
        tag_d = tag_q;
        st_d  = st_q;
        if (we) begin
            tag_d[w_idx] = w_tag;
            st_d[w_idx]  = w_st;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_I;
            end
        end else begin
            tag_q <= tag_d;
            st_q  <= st_d;
        end
    end

    assign ra_tag = tag_q[ra_idx];
    assign ra_st  = st_q[ra_idx];
    assign rb_tag = tag_q[rb_idx];
    assign rb_st  = st_q[rb_idx];

endmodule

// File: rtl/mesi_snoop_eval.sv
module mesi_snoop_eval
    import mesi_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             act,
    input  bus_cmd_t         cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_t         line_st,
    output logic             has_copy,
    output logic             has_dirty,
    output logic             upd,
    output line_st_t         nxt_st
);
    logic hit;

    always_comb begin
        hit       = act && (line_st != ST_I) && (line_tag == snp_tag);
        has_copy  = hit && (cmd != CMD_WB);
        has_dirty = has_copy && (line_st == ST_M);
        nxt_st    = line_st;
        if (has_copy) begin
            unique case (cmd)
                CMD_RD:  nxt_st = ST_S;
                CMD_RDX,
                CMD_UPG: nxt_st = ST_I;
                default: nxt_st = line_st;
            endcase
        end
        upd = has_copy && (nxt_st != line_st);
    end

endmodule

// File: rtl/mesi_miss_plan.sv
module mesi_miss_plan
    import mesi_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 12
) (
    input  logic [TAG_W-1:0]       req_tag,
    input  logic [IDX_W-1:0]       req_idx,
    input  logic                   req_wr,
    input  logic [TAG_W-1:0]       line_tag,
    input  line_st_t               line_st,
    output bus_cmd_t               cmd,
    output logic [TAG_W+IDX_W-1:0] addr
);
    logic victim_dirty;
    logic match;

    always_comb begin
        victim_dirty = (line_st == ST_M) && (line_tag != req_tag);
        match        = (line_st != ST_I) && (line_tag == req_tag);
        addr         = {req_tag, req_idx};
        if (victim_dirty) begin
            cmd  = CMD_WB;
            addr = {line_tag, req_idx};
        end else if (req_wr) begin
            cmd = (match && line_st == ST_S) ? CMD_UPG : CMD_RDX;
        end else begin
            cmd = CMD_RD;
        end
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_req_grant,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_has_copy,
    output logic              snp_has_dirty,
    output logic              snp_wait
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic {PH_IDLE, PH_BUS} phase_t;

    typedef struct packed {
        phase_t            phase;
        logic [ADDR_W-1:0] req_addr;
        logic              req_wr;
        logic              done;
        logic              sp_pend;
        bus_cmd_t          sp_cmd;
        logic [ADDR_W-1:0] sp_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Tag store ports
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [TAG_W-1:0]  ra_tag;
    line_st_t          ra_st;
    logic [TAG_W-1:0]  rb_tag;
    line_st_t          rb_st;
    logic              we;
    logic [IDX_W-1:0]  w_idx;
    logic [TAG_W-1:0]  w_tag;
    line_st_t          w_st;

    // Snoop path
    logic              snp_act;
    bus_cmd_t          eff_cmd;
    logic [ADDR_W-1:0] eff_addr;
    logic              sn_copy;
    logic              sn_dirty;
    logic              sn_upd;
    line_st_t          sn_nxt;

    // Request path
    logic              accept;
    logic              hit;
    bus_cmd_t          plan_cmd;
    logic [ADDR_W-1:0] plan_addr;

    // A deferred snoop takes priority over a fresh one; a fresh one is deferred
    // when the processor owns the tag lookup in this cycle.
    always_comb begin
        cpu_req_ready = (ctl_q.phase == PH_IDLE) && !ctl_q.sp_pend;
        accept        = cpu_req_valid && cpu_req_ready;
        snp_wait      = snp_valid && accept;
        snp_act       = ctl_q.sp_pend || (snp_valid && !accept);
        eff_cmd       = ctl_q.sp_pend ? ctl_q.sp_cmd  : bus_cmd_t'(snp_cmd);
        eff_addr      = ctl_q.sp_pend ? ctl_q.sp_addr : snp_addr;
        lk_idx        = (ctl_q.phase == PH_IDLE) ? cpu_req_addr[IDX_W-1:0]
                                                 : ctl_q.req_addr[IDX_W-1:0];
        lk_tag        = (ctl_q.phase == PH_IDLE) ? cpu_req_addr[ADDR_W-1:IDX_W]
                                                 : ctl_q.req_addr[ADDR_W-1:IDX_W];
        hit           = (ra_st != ST_I) && (ra_tag == lk_tag);
    end

    mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .ra_idx (lk_idx),
        .ra_tag (ra_tag),
        .ra_st  (ra_st),
        .rb_idx (eff_addr[IDX_W-1:0]),
        .rb_tag (rb_tag),
        .rb_st  (rb_st),
        .we     (we),
        .w_idx  (w_idx),
        .w_tag  (w_tag),
        .w_st   (w_st)
    );

    mesi_snoop_eval #(.TAG_W(TAG_W)) u_snoop (
        .act       (snp_act),
        .cmd       (eff_cmd),
        .snp_tag   (eff_addr[ADDR_W-1:IDX_W]),
        .line_tag  (rb_tag),
        .line_st   (rb_st),
        .has_copy  (sn_copy),
        .has_dirty (sn_dirty),
        .upd       (sn_upd),
        .nxt_st    (sn_nxt)
    );

    mesi_miss_plan #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_plan (
        .req_tag  (ctl_q.req_addr[ADDR_W-1:IDX_W]),
        .req_idx  (ctl_q.req_addr[IDX_W-1:0]),
        .req_wr   (ctl_q.req_wr),
        .line_tag (ra_tag),
        .line_st  (ra_st),
        .cmd      (plan_cmd),
        .addr     (plan_addr)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        we         = 1'b0;
        w_idx      = lk_idx;
        w_tag      = ra_tag;
        w_st       = ra_st;

        if (snp_wait) begin
            ctl_d.sp_pend = 1'b1;
            ctl_d.sp_cmd  = bus_cmd_t'(snp_cmd);
            ctl_d.sp_addr = snp_addr;
        end else if (ctl_q.sp_pend) begin
            ctl_d.sp_pend = 1'b0;
        end

        if (sn_upd) begin
            we    = 1'b1;
            w_idx = eff_addr[IDX_W-1:0];
            w_tag = rb_tag;
            w_st  = sn_nxt;
        end else if (accept) begin
            if (hit && (!cpu_req_write || ra_st == ST_E || ra_st == ST_M)) begin
                ctl_d.done = 1'b1;
                if (cpu_req_write && ra_st == ST_E) begin
                    we   = 1'b1;
                    w_st = ST_M;
                end
            end else begin
                ctl_d.phase    = PH_BUS;
                ctl_d.req_addr = cpu_req_addr;
                ctl_d.req_wr   = cpu_req_write;
            end
        end else if (ctl_q.phase == PH_BUS && bus_req_grant) begin
            we = 1'b1;
            unique case (plan_cmd)
                CMD_WB: begin
                    w_st = ST_I;
                end
                CMD_RD: begin
                    w_tag       = lk_tag;
                    w_st        = bus_shared_in ? ST_S : ST_E;
                    ctl_d.phase = PH_IDLE;
                    ctl_d.done  = 1'b1;
                end
                default: begin
                    w_tag       = lk_tag;
                    w_st        = ST_M;
                    ctl_d.phase = PH_IDLE;
                    ctl_d.done  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.phase    <= PH_IDLE;
            ctl_q.req_addr <= '0;
            ctl_q.req_wr   <= 1'b0;
            ctl_q.done     <= 1'b0;
            ctl_q.sp_pend  <= 1'b0;
            ctl_q.sp_cmd   <= CMD_WB;
            ctl_q.sp_addr  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_done      = ctl_q.done;
    assign bus_req_valid = (ctl_q.phase == PH_BUS);
    assign bus_req_cmd   = plan_cmd;
    assign bus_req_addr  = plan_addr;
    assign snp_has_copy  = sn_copy;
    assign snp_has_dirty = sn_dirty;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cpu_req_valid,
    input logic cpu_req_ready,
    input logic cpu_done,
    input logic bus_req_valid,
    input logic bus_req_grant,
    input logic snp_valid,
    input logic snp_has_copy,
    input logic snp_has_dirty,
    input logic snp_wait
);
    // R10: the wait line lasts a single cycle
    assert_wait_single_R10: assert property (@(posedge clk) disable iff (rst)
        snp_wait |=> !snp_wait);

    // R10: a wait is only raised for a snoop on the bus
    assert_wait_needs_snoop_R10: assert property (@(posedge clk) disable iff (rst)
        snp_wait |-> snp_valid);

    // R10: the cycle after a wait belongs to the deferred snoop
    assert_wait_blocks_cpu_R10: assert property (@(posedge clk) disable iff (rst)
        snp_wait |=> !cpu_req_ready);

    // R7: a dirty report always comes with a copy report
    assert_dirty_has_copy_R7: assert property (@(posedge clk) disable iff (rst)
        snp_has_dirty |-> snp_has_copy);

    // R11: request held until granted
    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_req_grant) |=> bus_req_valid);

    // R11: no new processor request while one bus request is outstanding
    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !cpu_req_ready);

    // R4: completion follows an acceptance or a grant
    assert_done_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> ($past(cpu_req_valid && cpu_req_ready) || $past(bus_req_valid && bus_req_grant)));
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_done      (cpu_done),
    .bus_req_valid (bus_req_valid),
    .bus_req_grant (bus_req_grant),
    .snp_valid     (snp_valid),
    .snp_has_copy  (snp_has_copy),
    .snp_has_dirty (snp_has_dirty),
    .snp_wait      (snp_wait)
);

// File: tb/tb_mesi_snoop_ctrl.sv
module tb_mesi_snoop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [1:0] C_WB = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_UPG = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          cpu_req_ready;
    logic          cpu_done;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic          bus_req_grant = 1'b0;
    logic          bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_has_copy;
    logic          snp_has_dirty;
    logic          snp_wait;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(4)) dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_ready(cpu_req_ready),
        .cpu_done(cpu_done),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_grant(bus_req_grant),
        .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_has_copy(snp_has_copy), .snp_has_dirty(snp_has_dirty),
        .snp_wait(snp_wait)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Processor access; expects n_exp bus transactions (c0/a0 then c1/a1).
    task automatic access(input logic [AW-1:0] a, input logic wr, input logic shr,
                          input int n_exp,
                          input logic [1:0] c0, input logic [AW-1:0] a0,
                          input logic [1:0] c1, input logic [AW-1:0] a1,
                          input string rq);
        int seen = 0;
        bit got_done = 1'b0;
        @(negedge clk);
        chk(rq, "ready before request", cpu_req_ready, 1);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (cpu_done) begin
                got_done = 1'b1;
                break;
            end
            if (bus_req_valid) begin
                chk(rq, "ready while busy", cpu_req_ready, 0);
                if (seen == 0) begin
                    chk(rq, "bus cmd #0", bus_req_cmd, c0);
                    chk(rq, "bus addr #0", bus_req_addr, a0);
                end else begin
                    chk(rq, "bus cmd #1", bus_req_cmd, c1);
                    chk(rq, "bus addr #1", bus_req_addr, a1);
                end
                bus_req_grant = 1'b1; bus_shared_in = shr;
                @(negedge clk);
                bus_req_grant = 1'b0; bus_shared_in = 1'b0;
                seen++;
            end else begin
                @(negedge clk);
            end
        end
        chk(rq, "done seen", got_done, 1);
        chk(rq, "bus transaction count", seen, n_exp);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         input logic e_copy, input logic e_dirty, input string rq);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        chk(rq, "snoop copy", snp_has_copy, e_copy);
        chk(rq, "snoop dirty", snp_has_dirty, e_dirty);
        chk(rq, "snoop wait", snp_wait, 0);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "ready", cpu_req_ready, 1);
        chk("R1", "bus idle", bus_req_valid, 0);
        chk("R1", "done low", cpu_done, 0);
        snoop(C_RD, 16'h0012, 0, 0, "R1");
        snoop(C_RDX, 16'h0F0F, 0, 0, "R1");
    endtask

    task automatic t_read_exclusive_clean();
        access(16'h0012, 0, 0, 1, C_RD, 16'h0012, C_RD, 0, "R5");
        access(16'h0012, 0, 0, 0, C_RD, 0, C_RD, 0, "R4");       // read hit
        access(16'h0012, 1, 0, 0, C_RD, 0, C_RD, 0, "R4");       // E -> M silent
        snoop(C_RD, 16'h0012, 1, 1, "R7");                        // M supplies, -> S
        snoop(C_RD, 16'h0012, 1, 0, "R6");                        // now shared
    endtask

    task automatic t_read_shared_upgrade();
        access(16'h0025, 0, 1, 1, C_RD, 16'h0025, C_RD, 0, "R5");
        access(16'h0025, 1, 0, 1, C_UPG, 16'h0025, C_RD, 0, "R3");
        snoop(C_RDX, 16'h0025, 1, 1, "R7");                       // M -> I
        snoop(C_RD, 16'h0025, 0, 0, "R7");
    endtask

    task automatic t_write_miss_evict();
        access(16'h0037, 1, 0, 1, C_RDX, 16'h0037, C_RD, 0, "R2");
        access(16'h0037, 1, 0, 0, C_RD, 0, C_RD, 0, "R2");       // already M
        access(16'h1037, 0, 1, 2, C_WB, 16'h0037, C_RD, 16'h1037, "R9");
        snoop(C_RD, 16'h0037, 0, 0, "R9");                        // victim gone
        access(16'h2037, 0, 0, 1, C_RD, 16'h2037, C_RD, 0, "R9"); // silent drop
    endtask

    task automatic t_exclusive_demote();
        access(16'h0048, 0, 0, 1, C_RD, 16'h0048, C_RD, 0, "R5");
        snoop(C_RD, 16'h0048, 1, 0, "R6");
        access(16'h0048, 1, 0, 1, C_UPG, 16'h0048, C_RD, 0, "R6");
    endtask

    task automatic t_invalidate_and_ignore();
        access(16'h0059, 0, 1, 1, C_RD, 16'h0059, C_RD, 0, "R5");
        snoop(C_UPG, 16'h0059, 1, 0, "R8");
        snoop(C_RD, 16'h0059, 0, 0, "R8");
        access(16'h008C, 1, 0, 1, C_RDX, 16'h008C, C_RD, 0, "R2");
        snoop(C_WB, 16'h008C, 0, 0, "R8");
        snoop(C_RD, 16'h108C, 0, 0, "R8");
        snoop(C_RD, 16'h008C, 1, 1, "R8");                        // still M
    endtask

    task automatic t_upgrade_race();
        access(16'h006A, 0, 1, 1, C_RD, 16'h006A, C_RD, 0, "R5");
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 16'h006A;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk("R12", "upgrade pending", bus_req_cmd, C_UPG);
        chk("R11", "request valid", bus_req_valid, 1);
        snp_valid = 1'b1; snp_cmd = C_RDX; snp_addr = 16'h006A;
        #1;
        chk("R12", "snoop copy", snp_has_copy, 1);
        @(negedge clk);
        snp_valid = 1'b0;
        chk("R11", "request held", bus_req_valid, 1);
        chk("R11", "ready low", cpu_req_ready, 0);
        chk("R12", "converted cmd", bus_req_cmd, C_RDX);
        chk("R12", "converted addr", bus_req_addr, 16'h006A);
        bus_req_grant = 1'b1;
        @(negedge clk);
        bus_req_grant = 1'b0;
        chk("R11", "done after grant", cpu_done, 1);
        @(negedge clk);
        chk("R11", "done is a pulse", cpu_done, 0);
        snoop(C_RD, 16'h006A, 1, 1, "R12");
    endtask

    task automatic t_collision();
        access(16'h007B, 0, 0, 1, C_RD, 16'h007B, C_RD, 0, "R5");
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 16'h007B;
        snp_valid = 1'b1; snp_cmd = C_RD; snp_addr = 16'h007B;
        #1;
        chk("R10", "wait raised", snp_wait, 1);
        chk("R10", "no copy yet", snp_has_copy, 0);
        @(negedge clk);
        cpu_req_valid = 1'b0; snp_valid = 1'b0;
        #1;
        chk("R10", "wait dropped", snp_wait, 0);
        chk("R10", "deferred copy", snp_has_copy, 1);
        chk("R10", "deferred dirty", snp_has_dirty, 1);
        chk("R10", "ready low", cpu_req_ready, 0);
        chk("R4", "write hit done", cpu_done, 1);
        @(negedge clk);
        chk("R10", "ready back", cpu_req_ready, 1);
        access(16'h007B, 1, 0, 1, C_UPG, 16'h007B, C_RD, 0, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_exclusive_clean();
        t_read_shared_upgrade();
        t_write_miss_evict();
        t_exclusive_demote();
        t_invalidate_and_ignore();
        t_upgrade_race();
        t_collision();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule